// File: doc/BRIEF.md
# Queued SPI Master Sequencer

This block is an SPI master that works through a small queue of transfers on its own. Software first loads the queue. Each slot holds an 8-bit command word and a 16-bit transmit word. Software then sets a start slot, an end slot, an optional wrap slot, two delays, the clock divider, the clock polarity and phase, and a bit-count field. Setup finishes with a rising edge on `enable`.

For each slot in turn, the sequencer does four things:
- it fetches the slot;
- it asserts the chip selects that the command word names;
- it waits an optional lead-in delay, then shifts the word out MSB first while shifting a reply in;
- it writes the reply, right-justified, into the receive half of the same slot, releases the chip selects and waits an optional trail delay.

After the end slot the engine either stops or continues from the wrap slot. Finishing the end slot sets a sticky completion flag. A halt request stops the engine cleanly between slots. Each of these two events can drive the interrupt line through its own enable. A loopback switch feeds the serial output straight back into the serial input, so the block can test itself without a slave attached.

Top module: `qspi_seq_master`

## Requirements
- R1: After reset, `busy`, `halted`, `done_flag` and `irq` are 0 and `cs_n` is all ones.
- R2: A rising edge of `enable` starts the engine at `start_ptr`. Slots then run in ascending order, modulo 16 (slot 15 is followed by 0), through `end_ptr`. With `wrap_en` low the engine then stops and `busy` falls.
- R3: Command word layout: bits [3:0] select chip selects, and `cs_n[i]` is driven low for the whole transfer when bit i is 1. Bit 4 enables the lead-in delay. Bit 5 enables the trail delay. Bit 6 selects the programmed bit count. Bit 7 suppresses the receive write-back.
- R4: With `wrap_en` high, the slot after `end_ptr` is `wrap_ptr` and the engine keeps running. When `enable` is dropped, the engine finishes the current slot and goes idle.
- R5: When bit 4 of the command word is set, the time from chip-select assertion to the first SCK edge grows by exactly `pre_dly` clock cycles.
- R6: When bit 5 of the command word is set, the time from chip-select release to the next slot's chip-select assertion grows by exactly `post_dly` cycles.
- R7: SCK idles at `cpol`. During a transfer, consecutive SCK edges are `baud_div`+1 clock cycles apart.
- R8: Data is MSB first. With `cpha`=0, data is sampled on the leading edge and changed on the trailing edge. With `cpha`=1, data is changed on the leading edge and sampled on the trailing edge.
- R9: Bit count: 8 bits when command bit 6 is clear. When bit 6 is set, `bits_cfg`=0 gives 16 bits, 1 to 7 gives 8 bits, and 8 to 15 gives that many bits.
- R10: The received word is stored right-justified (upper bits zero) in the receive word of the slot that was transferred, unless command bit 7 is set, in which case the slot keeps its previous value.
- R11: With `loopback` high, the received word equals the transmitted word whatever `miso` does.
- R12: If `halt_req` is high when a slot ends, the engine stops with `halted` high, all chip selects released and `cur_ptr` on the next slot. It resumes from that slot when `halt_req` falls. `irq` is high while halted if `halt_irq_en` is set.
- R13: `done_flag` is set when the end slot finishes and holds until `done_clr`. `irq` follows `done_flag` only while `done_irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Rising edge starts the queue; low stops it after the current slot |
| start_ptr | input | 4 | First slot |
| end_ptr | input | 4 | Last slot |
| wrap_en | input | 1 | Continue at wrap_ptr after end_ptr |
| wrap_ptr | input | 4 | Slot after end_ptr when wrapping |
| halt_req | input | 1 | Stop between slots |
| done_irq_en | input | 1 | Gates done_flag onto irq |
| halt_irq_en | input | 1 | Gates halted onto irq |
| done_clr | input | 1 | Clears done_flag |
| baud_div | input | 8 | SCK half period minus one, in clocks |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | Clock phase |
| bits_cfg | input | 4 | Programmed bit count |
| pre_dly | input | 8 | Lead-in delay in clocks |
| post_dly | input | 8 | Trail delay in clocks |
| loopback | input | 1 | Route serial output to serial input |
| q_we | input | 1 | Queue slot write strobe |
| q_addr | input | 4 | Queue slot written |
| q_cmd | input | 8 | Command word written |
| q_tx | input | 16 | Transmit word written |
| rx_addr | input | 4 | Receive slot read address |
| rx_data | output | 16 | Receive word of slot rx_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Engine running or halted |
| halted | output | 1 | Stopped by halt request |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt |
| cur_ptr | output | 4 | Slot being worked on |

## Verification
On every cycle, the assertions check the following:
- an idle engine drives no chip select and holds SCK at its polarity;
- a halted engine has released the bus and is not shifting;
- the queue pointer only steps by one or jumps to the wrap slot;
- the completion flag rises only as the end slot retires;
- the shifter never counts past its last edge.

Only the bench scenarios can show the rest:
- the exact bits on the wire in each clock mode and the resulting receive words;
- the mapping of bit counts;
- the slot order through wrap and rollover;
- the exact cycle cost of the two delays;
- the effects of loopback and of resuming after a halt.

// File: rtl/qs_pkg.sv
package qs_pkg;
    localparam int QS_CS_W     = 4;
    localparam int QS_MIN_BITS = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_PRE, S_XFER, S_POST, S_HALT
    } qs_state_e;

    // bit 7 no_store, 6 use_bits, 5 post_en, 4 pre_en, 3:0 chip selects
    typedef struct packed {
        logic               no_store;
        logic               use_bits;
        logic               post_en;
        logic               pre_en;
        logic [QS_CS_W-1:0] cs;
    } qs_cmd_t;
endpackage

// File: rtl/qs_queue_ram.sv
module qs_queue_ram #(
    parameter int DEPTH  = 16,
    parameter int CMD_W  = 8,
    parameter int DATA_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [AW-1:0]     sw_addr,
    input  logic [CMD_W-1:0]  sw_cmd,
    input  logic [DATA_W-1:0] sw_tx,
    input  logic [AW-1:0]     eng_addr,
    output logic [CMD_W-1:0]  eng_cmd,
    output logic [DATA_W-1:0] eng_tx,
    input  logic              eng_rx_we,
    input  logic [DATA_W-1:0] eng_rx,
    input  logic [AW-1:0]     sw_rx_addr,
    output logic [DATA_W-1:0] sw_rx
);
    logic [CMD_W-1:0]  cmd_d [DEPTH];
    logic [CMD_W-1:0]  cmd_q [DEPTH];
    logic [DATA_W-1:0] tx_d  [DEPTH];
    logic [DATA_W-1:0] tx_q  [DEPTH];
    logic [DATA_W-1:0] rx_d  [DEPTH];
    logic [DATA_W-1:0] rx_q  [DEPTH];

    always_comb begin
        cmd_d = cmd_q;
        tx_d  = tx_q;
        rx_d  = rx_q;
        if (sw_we) begin
            cmd_d[sw_addr] = sw_cmd;
            tx_d[sw_addr]  = sw_tx;
        end
        if (eng_rx_we) begin
            rx_d[eng_addr] = eng_rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{default: '0};
            tx_q  <= '{default: '0};
            rx_q  <= '{default: '0};
        end else begin
            cmd_q <= cmd_d;
            tx_q  <= tx_d;
            rx_q  <= rx_d;
        end
    end

    assign eng_cmd = cmd_q[eng_addr];
    assign eng_tx  = tx_q[eng_addr];
    assign sw_rx   = rx_q[sw_rx_addr];
endmodule

// File: rtl/qs_timer.sv
module qs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/qs_shifter.sv
module qs_shifter #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int CNT_W = $clog2(DATA_W + 1),
    localparam int ECW   = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [CNT_W-1:0]  nbits,
    input  logic [DIV_W-1:0]  div,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic              active,
    output logic [DATA_W-1:0] rx_word
);
    typedef struct packed {
        logic              active;
        logic              done;
        logic              sck;
        logic [DIV_W-1:0]  div_cnt;
        logic [ECW-1:0]    edge_cnt;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
    } sh_state_t;

    sh_state_t      d, q;
    logic           lead;
    logic [CNT_W-1:0] lsh;
    logic [ECW-1:0] last_edge;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        lead      = ~q.edge_cnt[0];
        lsh       = CNT_W'(DATA_W) - nbits;
        last_edge = {nbits, 1'b0} - ECW'(1);
        if (!q.active) begin
            if (start) begin
                d.active   = 1'b1;
                d.sck      = cpol;
                d.div_cnt  = '0;
                d.edge_cnt = '0;
                d.tx_sh    = tx_word << lsh;
                d.rx_sh    = '0;
            end
        end else if (q.div_cnt == div) begin
            d.div_cnt = '0;
            d.sck     = ~q.sck;
            if (lead ^ cpha) begin
                d.rx_sh = {q.rx_sh[DATA_W-2:0], miso};
            end else if (q.edge_cnt != '0) begin
                d.tx_sh = {q.tx_sh[DATA_W-2:0], 1'b0};
            end
            d.edge_cnt = q.edge_cnt + ECW'(1);
            if (q.edge_cnt == last_edge) begin
                d.active = 1'b0;
                d.done   = 1'b1;
            end
        end else begin
            d.div_cnt = q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sck     = q.active ? q.sck : cpol;
    assign mosi    = q.tx_sh[DATA_W-1];
    assign done    = q.done;
    assign active  = q.active;
    assign rx_word = q.rx_sh;

    // R8
    edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.active |-> (q.edge_cnt < ECW'(2 * DATA_W)));

    // R9
    edge_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.edge_cnt == {nbits, 1'b0}));
endmodule

// File: rtl/qspi_seq_master.sv
module qspi_seq_master
    import qs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int DLY_W  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DATA_W + 1),
    localparam int BCF_W = $clog2(DATA_W),
    localparam int CMD_W = $bits(qs_cmd_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [AW-1:0]     start_ptr,
    input  logic [AW-1:0]     end_ptr,
    input  logic              wrap_en,
    input  logic [AW-1:0]     wrap_ptr,
    input  logic              halt_req,
    input  logic              done_irq_en,
    input  logic              halt_irq_en,
    input  logic              done_clr,
    input  logic [DIV_W-1:0]  baud_div,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [BCF_W-1:0]  bits_cfg,
    input  logic [DLY_W-1:0]  pre_dly,
    input  logic [DLY_W-1:0]  post_dly,
    input  logic              loopback,
    input  logic              q_we,
    input  logic [AW-1:0]     q_addr,
    input  logic [CMD_W-1:0]  q_cmd,
    input  logic [DATA_W-1:0] q_tx,
    input  logic [AW-1:0]     rx_addr,
    output logic [DATA_W-1:0] rx_data,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [QS_CS_W-1:0] cs_n,
    output logic              busy,
    output logic              halted,
    output logic              done_flag,
    output logic              irq,
    output logic [AW-1:0]     cur_ptr
);
    typedef struct packed {
        qs_state_e          state;
        logic [AW-1:0]      ptr;
        logic [QS_CS_W-1:0] cs;
        logic               post_en;
        logic               no_store;
        logic [DATA_W-1:0]  tx;
        logic [CNT_W-1:0]   nbits;
        logic               done;
        logic               en_prev;
    } seq_state_t;

    seq_state_t         d, q;
    logic [CMD_W-1:0]   ram_cmd_raw;
    qs_cmd_t            ram_cmd;
    logic [DATA_W-1:0]  ram_tx;
    logic [CNT_W-1:0]   nb_res;
    logic               sh_start, sh_done, sh_active, sh_mosi, miso_i;
    logic [DATA_W-1:0]  sh_rx;
    logic               tmr_load, tmr_zero, rx_we, fin;
    logic [DLY_W-1:0]   tmr_val;

    qs_queue_ram #(.DEPTH(DEPTH), .CMD_W(CMD_W), .DATA_W(DATA_W)) i_ram (
        .clk(clk), .rst_n(rst_n),
        .sw_we(q_we), .sw_addr(q_addr), .sw_cmd(q_cmd), .sw_tx(q_tx),
        .eng_addr(q.ptr), .eng_cmd(ram_cmd_raw), .eng_tx(ram_tx),
        .eng_rx_we(rx_we), .eng_rx(sh_rx),
        .sw_rx_addr(rx_addr), .sw_rx(rx_data)
    );

    qs_timer #(.W(DLY_W)) i_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    assign miso_i = loopback ? sh_mosi : miso;

    qs_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(q.tx), .nbits(q.nbits),
        .div(baud_div), .cpol(cpol), .cpha(cpha), .miso(miso_i),
        .sck(sck), .mosi(sh_mosi), .done(sh_done), .active(sh_active), .rx_word(sh_rx)
    );

    assign ram_cmd = qs_cmd_t'(ram_cmd_raw);

    // bit-count resolution
    always_comb begin
        if (!ram_cmd.use_bits)                    nb_res = CNT_W'(QS_MIN_BITS);
        else if (bits_cfg == '0)                  nb_res = CNT_W'(DATA_W);
        else if (bits_cfg < BCF_W'(QS_MIN_BITS))  nb_res = CNT_W'(QS_MIN_BITS);
        else                                      nb_res = CNT_W'(bits_cfg);
    end

    always_comb begin
        d         = q;
        d.en_prev = enable;
        sh_start  = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rx_we     = 1'b0;
        fin       = 1'b0;
        if (done_clr) d.done = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (enable && !q.en_prev) begin
                    d.ptr   = start_ptr;
                    d.state = S_FETCH;
                end
            end
            S_FETCH: begin
                d.cs       = ram_cmd.cs;
                d.post_en  = ram_cmd.post_en;
                d.no_store = ram_cmd.no_store;
                d.tx       = ram_tx;
                d.nbits    = nb_res;
                tmr_load   = 1'b1;
                tmr_val    = ram_cmd.pre_en ? pre_dly : '0;
                d.state    = S_PRE;
            end
            S_PRE: begin
                if (tmr_zero) begin
                    sh_start = 1'b1;
                    d.state  = S_XFER;
                end
            end
            S_XFER: begin
                if (sh_done) begin
                    rx_we    = !q.no_store;
                    d.cs     = '0;
                    tmr_load = 1'b1;
                    tmr_val  = q.post_en ? post_dly : '0;
                    d.state  = S_POST;
                end
            end
            S_POST: begin
                if (tmr_zero) begin
                    if (q.ptr == end_ptr) begin
                        d.done = 1'b1;
                        if (wrap_en) d.ptr = wrap_ptr;
                        else         fin   = 1'b1;
                    end else begin
                        d.ptr = q.ptr + 1'b1;
                    end
                    if (fin || !enable) d.state = S_IDLE;
                    else if (halt_req)  d.state = S_HALT;
                    else                d.state = S_FETCH;
                end
            end
            S_HALT: begin
                if (!enable)       d.state = S_IDLE;
                else if (!halt_req) d.state = S_FETCH;
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mosi      = sh_mosi;
    assign cs_n      = ~q.cs;
    assign busy      = (q.state != S_IDLE);
    assign halted    = (q.state == S_HALT);
    assign done_flag = q.done;
    assign irq       = (q.done && done_irq_en) || (halted && halt_irq_en);
    assign cur_ptr   = q.ptr;

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    // R7
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cpol));

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> ((&cs_n) && !sh_active));

    // R2
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (q.ptr != $past(q.ptr)))
            |-> ((q.ptr == AW'($past(q.ptr) + 1'b1)) || (q.ptr == wrap_ptr)));

    // R13
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> ($past(q.ptr) == end_ptr));
endmodule

// File: tb/test_qspi_seq_master.sv
module test_qspi_seq_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        enable = 0, wrap_en = 0, halt_req = 0, done_irq_en = 0, halt_irq_en = 0, done_clr = 0;
    logic [3:0]  start_ptr = 0, end_ptr = 0, wrap_ptr = 0, bits_cfg = 0, q_addr = 0, rx_addr = 0;
    logic [7:0]  baud_div = 1, pre_dly = 0, post_dly = 0, q_cmd = 0;
    logic        cpol = 0, cpha = 0, loopback = 0, q_we = 0, miso = 0;
    logic [15:0] q_tx = 0, rx_data;
    logic        sck, mosi, busy, halted, done_flag, irq;
    logic [3:0]  cs_n, cur_ptr;

    int checks = 0, fails = 0, cyc = 0;

    qspi_seq_master i_qspi_seq_master (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_ptr(start_ptr), .end_ptr(end_ptr),
        .wrap_en(wrap_en), .wrap_ptr(wrap_ptr), .halt_req(halt_req), .done_irq_en(done_irq_en),
        .halt_irq_en(halt_irq_en), .done_clr(done_clr), .baud_div(baud_div), .cpol(cpol),
        .cpha(cpha), .bits_cfg(bits_cfg), .pre_dly(pre_dly), .post_dly(post_dly),
        .loopback(loopback), .q_we(q_we), .q_addr(q_addr), .q_cmd(q_cmd), .q_tx(q_tx),
        .rx_addr(rx_addr), .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n), .busy(busy), .halted(halted), .done_flag(done_flag), .irq(irq),
        .cur_ptr(cur_ptr)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // ---------------- slave model and bus monitor ----------------
    logic [15:0] slv_tab [16];
    logic [15:0] slv_word, slv_cap;
    logic [15:0] cap_log [32];
    logic [3:0]  ptr_log [32];
    logic [3:0]  csn_log [32];
    int          slv_k, exp_n = 8, log_n = 0;
    int          t_fall, t_rise = -1, gap_pre, gap_post, half_p, last_edge;
    bit          seen_edge;
    logic        cs_any, lead;
    assign cs_any = ~&cs_n;

    always @(posedge cs_any) begin
        slv_word = slv_tab[cur_ptr];
        slv_cap  = '0;
        if (!cpha) begin miso = slv_word[exp_n-1]; slv_k = exp_n - 2; end
        else       slv_k = exp_n - 1;
        if (t_rise >= 0) gap_post = cyc - t_rise;
        t_fall = cyc; seen_edge = 0;
        ptr_log[log_n] = cur_ptr; csn_log[log_n] = cs_n;
        log_n++;
    end

    always @(negedge cs_any) begin
        cap_log[log_n-1] = slv_cap;
        t_rise = cyc;
    end

    always @(sck) begin
        if (cs_any) begin
            if (!seen_edge) begin gap_pre = cyc - t_fall; seen_edge = 1; end
            else half_p = cyc - last_edge;
            last_edge = cyc;
            lead = (sck != cpol);
            if (lead ^ cpha) slv_cap = {slv_cap[14:0], mosi};
            else begin
                if (slv_k >= 0) miso = slv_word[slv_k];
                slv_k--;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] msk(input int n);
        return (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
    endfunction

    task automatic put(input int idx, input logic [7:0] cmd, input logic [15:0] tx);
        @(negedge clk);
        q_we = 1; q_addr = 4'(idx); q_cmd = cmd; q_tx = tx;
        @(negedge clk);
        q_we = 0;
    endtask

    task automatic get_rx(input int idx, output logic [15:0] v);
        @(negedge clk);
        rx_addr = 4'(idx); #1; v = rx_data;
    endtask

    task automatic run_queue(input int s, input int e);
        @(negedge clk);
        start_ptr = 4'(s); end_ptr = 4'(e); log_n = 0; t_rise = -1; enable = 1;
        @(negedge clk);
        while (busy) @(negedge clk);
        enable = 0;
        @(negedge clk);
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "cs_n", cs_n, 4'hF);
        chk("R1", "done", done_flag, 0);
        chk("R1", "irq", irq, 0);
        cpol = 1; #1;
        chk("R7", "sck idle at cpol=1", sck, 1);
        cpol = 0; #1;
        chk("R7", "sck idle at cpol=0", sck, 0);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        exp_n = 8; cpol = 0; cpha = 0; baud_div = 1;
        put(0, 8'h01, 16'h00A5); put(1, 8'h02, 16'h003C); put(2, 8'h84, 16'h0081);
        run_queue(0, 2);
        chk("R2", "entries run", log_n, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2", "slot order", ptr_log[i], i);
            chk("R3", "chip select", csn_log[i], ~(4'b1 << i) & 4'hF);
        end
        chk("R8", "mosi word 0", cap_log[0], 16'h00A5);
        chk("R8", "mosi word 2", cap_log[2], 16'h0081);
        get_rx(0, v); chk("R10", "rx slot 0", v, slv_tab[0] & msk(8));
        get_rx(1, v); chk("R10", "rx slot 1", v, slv_tab[1] & msk(8));
        get_rx(2, v); chk("R10", "no-store slot 2 unchanged", v, 0);
        chk("R2", "busy low at end", busy, 0);
        chk("R13", "done set", done_flag, 1);
        chk("R13", "irq gated off", irq, 0);
    endtask

    task automatic t_modes();
        logic [15:0] v;
        exp_n = 16; bits_cfg = 0;
        for (int m = 0; m < 4; m++) begin
            cpol = m[1]; cpha = m[0];
            put(5, 8'h48, 16'hC3A5 ^ 16'(m * 16'h1111));
            run_queue(5, 5);
            chk("R8", $sformatf("mosi mode %0d", m), cap_log[0], 16'hC3A5 ^ 16'(m * 16'h1111));
            get_rx(5, v);
            chk("R8", $sformatf("rx mode %0d", m), v, slv_tab[5]);
        end
        cpol = 0; cpha = 0;
    endtask

    task automatic t_bits();
        logic [15:0] v;
        exp_n = 12; bits_cfg = 12;
        put(6, 8'h41, 16'h0ABC); run_queue(6, 6);
        chk("R9", "12-bit mosi", cap_log[0], 16'h0ABC);
        get_rx(6, v); chk("R9", "12-bit rx right-justified", v, slv_tab[6] & msk(12));
        exp_n = 8; bits_cfg = 3;
        put(7, 8'h41, 16'h005A); run_queue(7, 7);
        get_rx(7, v); chk("R9", "cfg 3 gives 8 bits", v, slv_tab[7] & msk(8));
        bits_cfg = 0;
    endtask

    task automatic t_wrap();
        exp_n = 8;
        for (int i = 0; i < 16; i++) put(i, 8'h01, 16'(i));
        run_queue(14, 1);
        chk("R2", "rollover count", log_n, 4);
        chk("R2", "rollover third slot", ptr_log[2], 0);
        chk("R2", "rollover last slot", ptr_log[3], 1);
        wrap_en = 1; wrap_ptr = 1;
        @(negedge clk);
        start_ptr = 2; end_ptr = 4; log_n = 0; enable = 1;
        while (log_n < 6) @(negedge clk);
        enable = 0;
        while (busy) @(negedge clk);
        chk("R4", "stops after current slot", log_n, 6);
        chk("R4", "wrap slot", ptr_log[3], 1);
        chk("R4", "after wrap", ptr_log[5], 3);
        wrap_en = 0;
    endtask

    task automatic t_delays();
        int g0, g1;
        exp_n = 8; baud_div = 3;
        put(3, 8'h01, 16'h0011); put(4, 8'h01, 16'h0022);
        run_queue(3, 3); g0 = gap_pre;
        chk("R7", "half period", half_p, 4);
        pre_dly = 7; put(3, 8'h11, 16'h0011);
        run_queue(3, 3); g1 = gap_pre;
        chk("R5", "lead-in delay cost", g1 - g0, 7);
        put(3, 8'h01, 16'h0011);
        run_queue(3, 4); g0 = gap_post;
        post_dly = 5; put(3, 8'h21, 16'h0011);
        run_queue(3, 4); g1 = gap_post;
        chk("R6", "trail delay cost", g1 - g0, 5);
        baud_div = 1; pre_dly = 0; post_dly = 0;
    endtask

    task automatic t_halt();
        exp_n = 8;
        clear_done();
        for (int i = 0; i < 3; i++) put(i, 8'h02, 16'(16'h50 + i));
        halt_irq_en = 1; halt_req = 1;
        @(negedge clk);
        start_ptr = 0; end_ptr = 2; log_n = 0; enable = 1;
        while (!halted) @(negedge clk);
        chk("R12", "one slot before halt", log_n, 1);
        chk("R12", "cs released", cs_n, 4'hF);
        chk("R12", "pointer on next slot", cur_ptr, 1);
        chk("R12", "halt irq", irq, 1);
        halt_req = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        enable = 0;
        chk("R12", "resumed to end", log_n, 3);
        chk("R12", "resume slot", ptr_log[1], 1);
        halt_irq_en = 0;
    endtask

    task automatic t_loop();
        logic [15:0] v;
        exp_n = 16; bits_cfg = 0; loopback = 1;
        put(9, 8'h41, 16'h9E37);
        run_queue(9, 9);
        get_rx(9, v); chk("R11", "loopback rx equals tx", v, 16'h9E37);
        loopback = 0;
    endtask

    task automatic t_irq();
        clear_done();
        chk("R13", "done cleared", done_flag, 0);
        put(8, 8'h01, 16'h0042); exp_n = 8;
        run_queue(8, 8);
        chk("R13", "done sticky", done_flag, 1);
        chk("R13", "irq off while disabled", irq, 0);
        done_irq_en = 1; #1;
        chk("R13", "irq follows done", irq, 1);
        clear_done();
        chk("R13", "irq drops on clear", irq, 0);
        done_irq_en = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) slv_tab[i] = 16'h6B1D ^ 16'(i * 16'h0F13);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_basic();
        t_modes();
        t_bits();
        t_wrap();
        t_delays();
        t_halt();
        t_loop();
        t_irq();
        finish_run();
    end
endmodule